// File: doc/BRIEF.md
# Burst Address Sequencer with Ordering Select

This block produces the address for a four-beat cache-line burst. On any clock where a burst-start strobe is asserted, it captures an external address into a register. There are two active-low start strobes. One comes from the processor and is honoured only while the active-low chip select is asserted. The other comes from the cache controller and is always honoured. After the capture, an internal two-bit beat counter steps on each clock where the active-low advance input is low.

The two low-order output bits combine the captured low bits with the beat count. A static mode pin chooses the ordering. In linear ordering the low bits count up modulo four. In interleaved ordering they are the captured bits XOR the beat count. The upper address bits come straight from the capture register and do not change during a burst. Memory access, data and output enables belong to other blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `burst_addr` is all zeros until the first load.
- R2: A low `ctrl_strobe_n` at a rising edge loads `addr_in` and clears the beat count, whatever the level of `sel_n`. From the next edge on, `burst_addr` equals the loaded address.
- R3: A low `proc_strobe_n` together with a low `sel_n` at a rising edge loads `addr_in` in the same way as R2.
- R4: A low `proc_strobe_n` while `sel_n` is high is ignored. `burst_addr` keeps its previous value.
- R5: With `interleave` = 0, each edge with `adv_n` low and no load makes the low two bits of `burst_addr` equal to the loaded low bits plus the beat count, modulo 4. For example, a load of 1 gives 1,2,3,0.
- R6: With `interleave` = 1, the low two bits equal the loaded low bits XOR the beat count. For example, a load of 1 gives 1,0,3,2.
- R7: An edge with no load and `adv_n` high leaves `burst_addr` unchanged.
- R8: A load at the same edge as an advance wins. The beat count restarts at zero.
- R9: Bits above bit 1 of `burst_addr` change only on a load.
- R10: After four advances the beat count wraps, and `burst_addr` returns to the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | ADDR_W | External address to capture |
| proc_strobe_n | input | 1 | Processor burst-start strobe, active low, gated by `sel_n` |
| ctrl_strobe_n | input | 1 | Cache-controller burst-start strobe, active low |
| sel_n | input | 1 | Primary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Static ordering select: 0 linear, 1 interleaved |
| burst_addr | output | ADDR_W | Current burst address |

## Verification
Every load or advance is sampled at one rising edge. Its effect shows on `burst_addr` after that same edge, because one register stage lies between the inputs and the output. The mode pin acts on the output combinationally. The driver applies inputs at a falling edge, waits for the rising edge, and only then pushes the expected address from its own model. The monitor compares at the following falling edge, half a period after the result becomes due and before the next inputs reach the register.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              sel_n,
  input  logic              adv_n,
  input  logic              interleave,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic              load;
  logic [1:0]        lo_lin, lo_ilv;

  assign load = !ctrl_strobe_n || (!proc_strobe_n && !sel_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (!adv_n) begin
      beat_q <= beat_q + 2'd1;
    end
  end

  assign lo_lin = base_q[1:0] + beat_q;
  assign lo_ilv = base_q[1:0] ^ beat_q;

  assign burst_addr = {base_q[ADDR_W-1 -: HI_W], interleave ? lo_ilv : lo_lin};
endmodule

module burst_addr_seq_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_strobe_n,
  input logic              ctrl_strobe_n,
  input logic              sel_n,
  input logic              adv_n,
  input logic              interleave,
  input logic [ADDR_W-1:0] burst_addr
);
  logic       no_load;
  logic [1:0] lo_next;
  assign no_load = ctrl_strobe_n && (proc_strobe_n || sel_n);
  assign lo_next = burst_addr[1:0] + 2'd1;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_strobe_n |=> (burst_addr == $past(addr_in))); // R2
  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !sel_n) |=> (burst_addr == $past(addr_in))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && adv_n) |=> ($stable(interleave) -> $stable(burst_addr))); // R7
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    no_load |=> $stable(burst_addr[ADDR_W-1:2])); // R9
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_load && !adv_n && !interleave) |=> (interleave || burst_addr[1:0] == $past(lo_next))); // R5
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;
  localparam int W = 19;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [W-1:0] addr_in = '0;
  logic         proc_strobe_n = 1, ctrl_strobe_n = 1, sel_n = 1, adv_n = 1, interleave = 0;
  logic [W-1:0] burst_addr;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  logic [W-1:0] m_base = '0;
  logic [1:0]   m_beat = '0;

  burst_addr_seq #(.ADDR_W(W)) dut_i (.*);

  always #4 clk = ~clk;

  function automatic logic [W-1:0] model_out(input logic il);
    logic [1:0] lo;
    lo = il ? (m_base[1:0] ^ m_beat) : 2'((m_base[1:0] + m_beat) & 2'b11);
    return {m_base[W-1:2], lo};
  endfunction

  task automatic step(input logic cs, input logic ps, input logic sel, input logic adv,
                      input logic il, input logic [W-1:0] a, input string tag);
    @(negedge clk);
    ctrl_strobe_n = cs; proc_strobe_n = ps; sel_n = sel; adv_n = adv;
    interleave = il; addr_in = a;
    @(posedge clk);
    #1;
    if (!cs || (!ps && !sel)) begin
      m_base = a; m_beat = 2'd0;
    end else if (!adv) begin
      m_beat = m_beat + 2'd1;
    end
    exp_q.push_back(model_out(il));
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (burst_addr !== e) begin
        fails++;
        $display("FAIL %s: burst_addr=%h expected %h", t, burst_addr, e);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tests++;
    if (burst_addr !== '0) begin
      fails++; $display("FAIL R1: burst_addr=%h expected %h", burst_addr, {W{1'b0}});
    end
    @(negedge clk); rst_n = 1;
    step(1, 1, 1, 1, 0, 19'h7ffff, "R1_idle");
    // controller load with chip deselected
    step(0, 1, 1, 1, 0, 19'h12345, "R2");
    step(1, 1, 1, 0, 0, 19'h0, "R5_b1");
    step(1, 1, 1, 0, 0, 19'h0, "R5_b2_R9");
    step(1, 1, 1, 0, 0, 19'h0, "R5_b3");
    step(1, 1, 1, 0, 0, 19'h0, "R10_wrap");
    step(1, 1, 1, 1, 0, 19'h55555, "R7_hold");
    step(1, 1, 0, 1, 0, 19'h2aaaa, "R7_hold2");
    // processor strobe blocked by deselect
    step(1, 0, 1, 1, 0, 19'h0abcd, "R4");
    step(1, 0, 1, 0, 0, 19'h0abcd, "R4_adv");
    step(1, 0, 0, 1, 0, 19'h0abcd, "R3");
    step(1, 1, 0, 0, 0, 19'h0, "R5_p1");
    step(1, 1, 0, 0, 0, 19'h0, "R5_p2");
    step(1, 0, 0, 0, 0, 19'h3c002, "R8_proc");
    step(1, 1, 0, 0, 0, 19'h0, "R8_after");
    step(0, 1, 1, 0, 0, 19'h01237, "R8_ctrl");
    // interleaved ordering, load low bits = 1
    step(0, 1, 1, 1, 1, 19'h4f001, "R6_load");
    step(1, 1, 1, 0, 1, 19'h0, "R6_b1");
    step(1, 1, 1, 0, 1, 19'h0, "R6_b2_R9");
    step(1, 1, 1, 0, 1, 19'h0, "R6_b3");
    step(1, 1, 1, 0, 1, 19'h0, "R10_ilv_wrap");
    step(1, 1, 1, 0, 1, 19'h0, "R6_again");
    step(1, 1, 1, 1, 1, 19'h0, "R7_ilv");
    step(0, 1, 0, 1, 1, 19'h00002, "R2_sel_low");
    step(1, 1, 1, 0, 1, 19'h0, "R6_from2");
    step(1, 1, 1, 0, 1, 19'h0, "R6_from2b");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule